// File: doc/BRIEF.md
# Triple-Sample Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. The line idles high. A character opens with a low start bit, carries eight data bits least significant first, may carry one parity bit, and closes with a high stop bit. A divider derives a tick at sixteen times the bit rate from the system clock. The default rate is 57600 bit/s. A bit sequencer counts sixteen ticks per bit, starting from the first low level seen while idle.

Every bit is read at ticks 7, 8 and 9 of its sixteen ticks. This applies to the start and stop bits as well as the data and parity bits. The value of the bit is the majority of the three readings. Any disagreement among the three readings marks the character as noisy; the disagreement is never hidden. The block also reports parity and framing errors. Each finished character is presented as a byte with a one-clock valid strobe. Its three error flags appear in the same cycle as the byte.

Top module: `uart3s_rx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rx_valid`, `rx_data` and all three error flags are zero.
- R2: A clean frame delivers its data bits least significant first on `rx_data`. `rx_valid` is high for exactly one clock per character, and all three flags are zero.
- R3: Each bit is read at oversample ticks 7, 8 and 9 of its 16 ticks, and its value is the majority of the three readings. A single disagreeing reading inside a data bit leaves the delivered byte unchanged.
- R4: If the three readings of any bit of a character (start, data, parity or stop) are not all equal, `err_noise` is 1 for that character.
- R5: If the majority of the start-bit readings is high, the receiver returns to idle, does not pulse `rx_valid`, and accepts the next frame normally.
- R6: If the majority of the stop-bit readings is low, `err_frame` is 1 and the byte is still delivered.
- R7: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0 the data and parity bits together hold an even number of ones; with `par_odd`=1 they hold an odd number. A mismatch sets `err_parity`. When `par_en` is 0, the frame has no parity bit and `err_parity` is 0.
- R8: The flags belong only to the character that they accompany. A clean character that follows an erroneous one shows all three flags at zero. Between strobes, `rx_data` and the flags hold their values.
- R9: `rx_valid` pulses after the third stop-bit reading, and the receiver is idle at that point. A start bit that begins right at the end of the stop bit, with no idle gap, is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | 1: the frame carries a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a new byte |
| err_noise | output | 1 | Readings within some bit of this character disagreed |
| err_parity | output | 1 | The parity bit did not match |
| err_frame | output | 1 | The stop bit read low |

## Verification
The bench builds the block with CLK_HZ=1600000 and BAUD=25000, which gives a tick divider of 4 and a bit of 64 clocks. With this setting, more than twenty characters fit in a short run.

With a divider of 4, a 4-clock inverted pulse placed in the middle of a bit always covers exactly one of the three readings, whatever the phase of the free-running tick. This allows a one-reading disagreement to be injected into the start, data, parity or stop bit. The bench also covers both parity senses, a failed start, a low stop bit and back-to-back frames.

// File: rtl/uart3s_pkg.sv
package uart3s_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic agree3(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b111);
  endfunction

endpackage

// File: rtl/uart3s_tick.sv
module uart3s_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      logic          tick_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_r <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt    <= '0;
          tick_r <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          tick_r <= 1'b0;
        end
      end

      assign tick = tick_r;

      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/uart3s_sync.sv
module uart3s_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], line_i};
  end

  assign line_o = chain[STAGES-1];

endmodule

// File: rtl/uart3s_frame.sv
module uart3s_frame
  import uart3s_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx_s,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 err_noise,
  output logic                 err_parity,
  output logic                 err_frame
);

  localparam int TW     = $clog2(OSR);
  localparam int BW     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int SMP_B  = OSR / 2;
  localparam int SMP_A  = SMP_B - 1;
  localparam int SMP_C  = SMP_B + 1;

  rx_state_t            state;
  logic [TW-1:0]        tcnt;
  logic [BW-1:0]        bcnt;
  logic [1:0]           samp;
  logic                 noise_acc;
  logic                 par_bad;
  logic [DATA_BITS-1:0] shreg;

  logic [2:0] cur3;
  logic       bit_v;
  logic       clash;
  logic       at_eval;
  logic       bit_end;

  always_comb begin
    cur3    = {rx_s, samp};
    bit_v   = maj3(cur3);
    clash   = !agree3(cur3);
    at_eval = tick && (tcnt == TW'(SMP_C));
    bit_end = tick && (tcnt == TW'(OSR - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tcnt       <= '0;
      bcnt       <= '0;
      samp       <= '0;
      noise_acc  <= 1'b0;
      par_bad    <= 1'b0;
      shreg      <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_noise  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (state == ST_IDLE) begin
        if (!rx_s) begin
          state     <= ST_START;
          tcnt      <= '0;
          bcnt      <= '0;
          noise_acc <= 1'b0;
          par_bad   <= 1'b0;
        end
      end else if (tick) begin
        tcnt <= (tcnt == TW'(OSR - 1)) ? '0 : tcnt + 1'b1;
        if (tcnt == TW'(SMP_A)) samp[0] <= rx_s;
        if (tcnt == TW'(SMP_B)) samp[1] <= rx_s;

        if (at_eval) begin
          noise_acc <= noise_acc | clash;
          case (state)
            ST_START: if (bit_v) state <= ST_IDLE;
            ST_DATA:  shreg <= {bit_v, shreg[DATA_BITS-1:1]};
            ST_PAR:   par_bad <= (^shreg) ^ bit_v ^ par_odd;
            ST_STOP: begin
              rx_data    <= shreg;
              rx_valid   <= 1'b1;
              err_noise  <= noise_acc | clash;
              err_parity <= par_en & par_bad;
              err_frame  <= !bit_v;
              state      <= ST_IDLE;
            end
            default: ;
          endcase
        end

        if (bit_end) begin
          case (state)
            ST_START: state <= ST_DATA;
            ST_DATA: begin
              if (bcnt == BW'(DATA_BITS - 1)) state <= par_en ? ST_PAR : ST_STOP;
              bcnt <= bcnt + 1'b1;
            end
            ST_PAR:  state <= ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable({rx_data, err_noise, err_parity, err_frame}));

  // R9
  idle_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (state == ST_IDLE));

  // R5
  start_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) && at_eval && bit_v |=> (state == ST_IDLE) && !rx_valid);

endmodule

// File: rtl/uart3s_rx.sv
module uart3s_rx #(
  parameter int CLK_HZ      = 125_000_000,
  parameter int BAUD        = 57_600,
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 err_noise,
  output logic                 err_parity,
  output logic                 err_frame
);

  localparam int RAW_DIV = CLK_HZ / (BAUD * OSR);
  localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;

  logic tick;
  logic rx_s;

  uart3s_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  uart3s_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (rx_line),
    .line_o (rx_s)
  );

  uart3s_frame #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rx_s       (rx_s),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .err_noise  (err_noise),
    .err_parity (err_parity),
    .err_frame  (err_frame)
  );

endmodule

// File: tb/uart3s_rx_bench.sv
`timescale 1ns/1ps
module uart3s_rx_bench;

  localparam int CLK_HZ  = 1_600_000;
  localparam int BAUD    = 25_000;
  localparam int BIT_CLK = CLK_HZ / BAUD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_noise;
  logic       err_parity;
  logic       err_frame;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  prev_valid = 1'b0;

  logic [10:0] exq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  uart3s_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_uart3s_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_line    (rx_line),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .err_noise  (err_noise),
    .err_parity (err_parity),
    .err_frame  (err_frame)
  );

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prev_valid && rx_valid) begin
        total++; bad++;
        $display("FAIL R2 strobe longer than one clock: act=1 exp=0");
      end
      if (rx_valid) begin
        total++;
        if (exq.size() == 0) begin
          bad++;
          $display("FAIL R5 unexpected character: act=%h exp=none", rx_data);
        end else begin
          logic [10:0] e;
          string t;
          e = exq.pop_front();
          t = tagq.pop_front();
          if ({rx_data, err_noise, err_parity, err_frame} !== e) begin
            bad++;
            $display("FAIL %s data/noise/par/frame: act=%h/%b/%b/%b exp=%h/%b/%b/%b",
                     t, rx_data, err_noise, err_parity, err_frame,
                     e[10:3], e[2], e[1], e[0]);
          end
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic drive_bit(input logic v, input bit glitch);
    for (int c = 0; c < BIT_CLK; c++) begin
      @(negedge clk);
      rx_line = (glitch && c >= 34 && c <= 37) ? ~v : v;
    end
  endtask

  // gbit: -1 none, 0 start, 1..8 data, then parity (if any), then stop
  task automatic send(input logic [7:0] d, input int gbit, input bit pflip,
                      input logic stop_v, input int gap, input string tag);
    logic pbit;
    int   idx;
    pbit = (^d) ^ par_odd ^ pflip;
    exq.push_back({d, (gbit >= 0), (par_en & pflip), ~stop_v});
    tagq.push_back(tag);
    drive_bit(1'b0, gbit == 0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], gbit == i + 1);
    idx = 9;
    if (par_en) begin
      drive_bit(pbit, gbit == idx);
      idx++;
    end
    drive_bit(stop_v, gbit == idx);
    for (int g = 0; g < gap; g++) drive_bit(1'b1, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    total++;
    if ({rx_valid, rx_data, err_noise, err_parity, err_frame} !== 12'h0) begin
      bad++;
      $display("FAIL R1 in reset: act=%b%h%b%b%b exp=0", rx_valid, rx_data,
               err_noise, err_parity, err_frame);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if ({rx_valid, rx_data, err_noise, err_parity, err_frame} !== 12'h0) begin
      bad++;
      $display("FAIL R1 after reset: act=%b%h%b%b%b exp=0", rx_valid, rx_data,
               err_noise, err_parity, err_frame);
    end
    drive_bit(1'b1, 1'b0);

    send(8'h55, -1, 0, 1'b1, 1, "R2 clean");
    send(8'hA3,  4, 0, 1'b1, 1, "R3 data glitch majority");
    send(8'h0F, -1, 0, 1'b1, 1, "R8 clean after noise");
    send(8'h3C,  0, 0, 1'b1, 1, "R4 start glitch");
    send(8'hC1,  9, 0, 1'b1, 1, "R4 stop glitch");

    // R5: low pulse too short to be a start bit
    for (int c = 0; c < 20; c++) begin @(negedge clk); rx_line = 1'b0; end
    for (int c = 0; c < 3 * BIT_CLK; c++) begin @(negedge clk); rx_line = 1'b1; end
    send(8'h81, -1, 0, 1'b1, 1, "R5 frame after rejected start");

    send(8'h7E, -1, 0, 1'b0, 2, "R6 low stop");
    send(8'h12, -1, 0, 1'b1, 0, "R9 back-to-back first");
    send(8'h34, -1, 0, 1'b1, 1, "R9 back-to-back second");

    par_en = 1'b1; par_odd = 1'b0;
    send(8'h96, -1, 0, 1'b1, 1, "R7 even parity clean");
    send(8'h96, -1, 1, 1'b1, 1, "R7 even parity mismatch");
    send(8'h5A,  9, 0, 1'b1, 1, "R4 parity bit glitch");
    send(8'h6B, 10, 0, 1'b1, 1, "R4 stop glitch with parity");
    par_odd = 1'b1;
    send(8'h01, -1, 0, 1'b1, 1, "R7 odd parity clean");
    send(8'h01, -1, 1, 1'b1, 1, "R7 odd parity mismatch");
    send(8'hFF, -1, 0, 1'b0, 2, "R6 low stop with parity");
    send(8'h00, -1, 0, 1'b1, 1, "R8 clean after framing error");
    par_en = 1'b0;
    send(8'hE7, -1, 1, 1'b1, 1, "R7 parity off ignores flip");

    repeat (2 * BIT_CLK) @(negedge clk);
    total++;
    if (exq.size() != 0) begin
      bad++;
      $display("FAIL R2 missing characters: act=%0d exp=0", exq.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R2 watchdog expired: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule